// File: doc/BRIEF.md
# Clock Source Switch Controller

This block sequences clock-source changes for a set of independent clock selector channels. Software writes a channel's control word to name a new source, or to ask for the safe clock. The block takes the request, clears the request bit itself and runs a fixed-length switch sequence. During that sequence a busy flag is set. When the sequence ends, the channel's status word shows the source now in use, whether the safe clock is active, and an encoded cause for the last switch.

Each channel drives a select code and a safe-clock flag toward the clock path. A request to a source whose clock-good input is low, or to a source index the block does not have, does not report success. The channel falls back to the safe source instead, so a dead clock is never selected silently. Writes that arrive while a channel is busy are dropped. Software is expected to poll the busy flag before it issues the next request.

Top module: `clk_switch_ctrl`

## Requirements
- R1: Channel c has its control word at byte address 0x300 + c*0x40 and its status word at 0x300 + c*0x40 + 4. Reads of any other address return 0. Writes to a status word or to an unmapped address change nothing.
- R2: Control word layout: requested source in bits 29:24, switch request at bit 2, safe-clock request at bit 3. A write with neither request bit set stores the source field and starts no switch.
- R3: Both request bits clear themselves in the cycle after the write that set them, when the channel accepts the request. The source field is kept.
- R4: Status word layout: selected source in bits 29:24, trigger cause in bits 19:17, switch-in-progress at bit 16, safe-clock-active at bit 3. All other bits read 0. Cause codes: 0 none, 1 switch succeeded, 4 moved to the safe clock, 5 moved to the safe clock while it was already active.
- R5: The busy flag rises on the clock edge after the request write. It stays set for exactly SWITCH_CYCLES cycles and then clears, and the result appears on that same edge.
- R6: A switch request naming a source below NUM_SRC whose clock-good input is high ends with that source selected, cause 1, the safe flag clear, and the select code output equal to the source.
- R7: A safe-clock request ends with source SAFE_SRC, the safe flag set and cause 4, or cause 5 if the safe flag was already set. When both request bits are written together, the safe request wins.
- R8: A switch request whose source has its clock-good input low at completion, or whose index is NUM_SRC or more, ends like a safe-clock request: source SAFE_SRC, safe flag set, cause 4 or 5.
- R9: A control write made while a request is pending or a switch is in progress is ignored. The control word keeps its value and the switch in progress completes with the original request.
- R10: After reset every control word and status word reads 0, every select code is 0 and every safe flag is 0.
- R11: Channels are independent. A switch on one channel leaves another channel's status and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_good | input | NUM_SRC | Per-source clock-good indications |
| sel_code | output | NUM_CH*6 | Selected source code per channel, channel 0 in the low bits |
| safe_on | output | NUM_CH | Safe clock active, one bit per channel |

## Verification
The bench targets the handoff around the request bit. A design that clears the bit in the write cycle, or never clears it, fails the readback one and two cycles after the write. A design whose busy window is one cycle too short or too long is caught when the status is sampled on the last expected busy cycle and the first idle one. A late write into a running switch checks that the write is dropped; a design that lets it through shows the wrong source at completion. Fallback cases check that a dead or out-of-range source gives cause 4 or 5, not success, and that a repeated safe request gives cause 5 and not 4.

// File: rtl/csw_pkg.sv
package csw_pkg;

    // Field geometry of the register map
    localparam int SEL_W         = 6;
    localparam logic [11:0] CTRL_BASE = 12'h300;
    localparam int CH_STRIDE_LG  = 6;
    localparam int STAT_WORD_OFS = 4;
    localparam int SEL_LSB       = 24;
    localparam int SWREQ_BIT     = 2;
    localparam int SAFEREQ_BIT   = 3;
    localparam int BUSY_BIT      = 16;
    localparam int CAUSE_LSB     = 17;
    localparam int SAFEFLAG_BIT  = 3;

    typedef enum logic [2:0] {
        CAUSE_NONE       = 3'd0,
        CAUSE_OK         = 3'd1,
        CAUSE_SAFE       = 3'd4,
        CAUSE_SAFE_AGAIN = 3'd5
    } cause_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             safe_req;
        logic             sw_req;
    } ctrl_t;

    typedef struct packed {
        logic [SEL_W-1:0] src;
        cause_e           cause;
        logic             busy;
        logic             safe;
    } stat_t;

    function automatic logic [31:0] pack_ctrl(ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[SEL_LSB +: SEL_W] = c.sel;
        w[SWREQ_BIT]        = c.sw_req;
        w[SAFEREQ_BIT]      = c.safe_req;
        return w;
    endfunction

    function automatic ctrl_t unpack_ctrl(logic [31:0] w);
        ctrl_t c;
        c.sel      = w[SEL_LSB +: SEL_W];
        c.sw_req   = w[SWREQ_BIT];
        c.safe_req = w[SAFEREQ_BIT];
        return c;
    endfunction

    function automatic logic [31:0] pack_stat(stat_t s);
        logic [31:0] w;
        w = '0;
        w[SEL_LSB +: SEL_W] = s.src;
        w[CAUSE_LSB +: 3]   = s.cause;
        w[BUSY_BIT]         = s.busy;
        w[SAFEFLAG_BIT]     = s.safe;
        return w;
    endfunction

    function automatic cause_e safe_cause(logic was_safe);
        return was_safe ? CAUSE_SAFE_AGAIN : CAUSE_SAFE;
    endfunction

endpackage

// File: rtl/csw_regif.sv
module csw_regif
    import csw_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [NUM_CH-1:0][31:0]  ctrl_words,
    input  logic [NUM_CH-1:0][31:0]  stat_words,
    output logic [NUM_CH-1:0]        ctrl_wr,
    output logic [31:0]              bus_rdata
);
    localparam int CHF_W = ADDR_W - CH_STRIDE_LG;

    logic              in_win;
    logic [ADDR_W-1:0] off;
    logic [CHF_W-1:0]  ch_field;
    logic [CH_STRIDE_LG-1:0] word_ofs;
    logic [NUM_CH-1:0] hit_ctrl;
    logic [NUM_CH-1:0] hit_stat;

    always_comb begin
        in_win   = bus_addr >= ADDR_W'(CTRL_BASE);
        off      = bus_addr - ADDR_W'(CTRL_BASE);
        ch_field = off[ADDR_W-1:CH_STRIDE_LG];
        word_ofs = off[CH_STRIDE_LG-1:0];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
        logic ch_sel;
        assign ch_sel      = in_win && (ch_field == CHF_W'(c));
        assign hit_ctrl[c] = ch_sel && (word_ofs == '0);
        assign hit_stat[c] = ch_sel && (word_ofs == CH_STRIDE_LG'(STAT_WORD_OFS));
        assign ctrl_wr[c]  = bus_wr && hit_ctrl[c];
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (hit_ctrl[c]) bus_rdata = ctrl_words[c];
            if (hit_stat[c]) bus_rdata = stat_words[c];
        end
    end

    // R1
    one_target_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ctrl_wr));

    // R1
    no_stray_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr) |-> (ctrl_wr == '0));

endmodule

// File: rtl/csw_ctrl_reg.sv
module csw_ctrl_reg
    import csw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    input  logic        busy,
    input  logic        accept,
    output ctrl_t       ctrl
);
    logic wr_ok;

    // A write lands only while the channel neither runs nor accepts
    assign wr_ok = wr_en && !busy && !accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_ok) begin
            ctrl <= unpack_ctrl(wdata);
        end else if (accept) begin
            ctrl.sw_req   <= 1'b0;
            ctrl.safe_req <= 1'b0;
        end
    end

    // R3
    req_selfclear_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (!ctrl.sw_req && !ctrl.safe_req));

    // R9
    busy_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy) |=> $stable(ctrl));

    // R3
    sel_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !wr_en) |=> $stable(ctrl.sel));

endmodule

// File: rtl/csw_seq.sv
module csw_seq
    import csw_pkg::*;
#(
    parameter int NUM_SRC       = 8,
    parameter int SWITCH_CYCLES = 4,
    parameter int SAFE_SRC      = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  ctrl_t              ctrl,
    input  logic [NUM_SRC-1:0] src_good,
    output logic               accept,
    output stat_t              stat
);
    localparam int CNT_W = $clog2(SWITCH_CYCLES + 1);

    seq_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [SEL_W-1:0]  tgt;
    logic              want_safe;
    logic [SEL_W-1:0]  cur_src;
    logic              cur_safe;
    cause_e            cur_cause;
    logic              tgt_ok;

    assign accept = (state == ST_IDLE) && (ctrl.sw_req || ctrl.safe_req);

    // Target is usable only if it exists and its clock is good
    always_comb begin
        tgt_ok = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (tgt == SEL_W'(i)) tgt_ok = src_good[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            tgt       <= '0;
            want_safe <= 1'b0;
            cur_src   <= '0;
            cur_safe  <= 1'b0;
            cur_cause <= CAUSE_NONE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state     <= ST_RUN;
                        cnt       <= CNT_W'(SWITCH_CYCLES - 1);
                        tgt       <= ctrl.sel;
                        want_safe <= ctrl.safe_req;
                    end
                end
                ST_RUN: begin
                    if (cnt == '0) begin
                        state <= ST_IDLE;
                        if (!want_safe && tgt_ok) begin
                            cur_src   <= tgt;
                            cur_safe  <= 1'b0;
                            cur_cause <= CAUSE_OK;
                        end else begin
                            cur_src   <= SEL_W'(SAFE_SRC);
                            cur_safe  <= 1'b1;
                            cur_cause <= safe_cause(cur_safe);
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        stat.src   = cur_src;
        stat.cause = cur_cause;
        stat.busy  = (state == ST_RUN);
        stat.safe  = cur_safe;
    end

    // Checker: length of the current busy run
    logic [CNT_W:0] chk_len;
    always_ff @(posedge clk) begin
        if (rst || !stat.busy) chk_len <= '0;
        else                   chk_len <= chk_len + 1'b1;
    end

    // R5
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        stat.busy |-> (chk_len < (CNT_W+1)'(SWITCH_CYCLES)));

    // R5
    busy_exact_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(stat.busy) |-> ($past(chk_len) == (CNT_W+1)'(SWITCH_CYCLES - 1)));

    // R2
    no_req_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        (!stat.busy && !accept) |=> ($stable(cur_src) && $stable(cur_cause) && $stable(cur_safe)));

    // R4
    cause_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_cause == CAUSE_NONE) || (cur_cause == CAUSE_OK) ||
        (cur_cause == CAUSE_SAFE) || (cur_cause == CAUSE_SAFE_AGAIN));

    // R7
    safe_src_chk: assert property (@(posedge clk) disable iff (rst)
        cur_safe |-> (cur_src == SEL_W'(SAFE_SRC)));

    // R6
    ok_not_safe_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_cause == CAUSE_OK) |-> !cur_safe);

endmodule

// File: rtl/clk_switch_ctrl.sv
module clk_switch_ctrl
    import csw_pkg::*;
#(
    parameter int NUM_CH        = 2,
    parameter int NUM_SRC       = 8,
    parameter int SWITCH_CYCLES = 4,
    parameter int SAFE_SRC      = 0,
    parameter int ADDR_W        = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_SRC-1:0]        src_good,
    output logic [NUM_CH*SEL_W-1:0]   sel_code,
    output logic [NUM_CH-1:0]         safe_on
);
    logic [NUM_CH-1:0]       ctrl_wr;
    logic [NUM_CH-1:0][31:0] ctrl_words;
    logic [NUM_CH-1:0][31:0] stat_words;

    csw_regif #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_regif (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .ctrl_words (ctrl_words),
        .stat_words (stat_words),
        .ctrl_wr    (ctrl_wr),
        .bus_rdata  (bus_rdata)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ctrl_t ctrl;
        stat_t stat;
        logic  accept;

        csw_ctrl_reg u_ctrl (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (ctrl_wr[c]),
            .wdata  (bus_wdata),
            .busy   (stat.busy),
            .accept (accept),
            .ctrl   (ctrl)
        );

        csw_seq #(
            .NUM_SRC       (NUM_SRC),
            .SWITCH_CYCLES (SWITCH_CYCLES),
            .SAFE_SRC      (SAFE_SRC)
        ) u_seq (
            .clk      (clk),
            .rst      (rst),
            .ctrl     (ctrl),
            .src_good (src_good),
            .accept   (accept),
            .stat     (stat)
        );

        assign ctrl_words[c]              = pack_ctrl(ctrl);
        assign stat_words[c]              = pack_stat(stat);
        assign sel_code[c*SEL_W +: SEL_W] = stat.src;
        assign safe_on[c]                 = stat.safe;
    end

endmodule

// File: tb/sim_clk_switch_ctrl.sv
`timescale 1ns/1ps
module sim_clk_switch_ctrl;
    localparam int NCH = 2;
    localparam int NSRC = 8;
    localparam int CYC = 4;
    localparam int AW = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NSRC-1:0] src_good = '1;
    logic [NCH*6-1:0] sel_code;
    logic [NCH-1:0] safe_on;

    always #2.5 clk = ~clk;

    clk_switch_ctrl #(
        .NUM_CH(NCH), .NUM_SRC(NSRC), .SWITCH_CYCLES(CYC), .SAFE_SRC(0), .ADDR_W(AW)
    ) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_good(src_good),
        .sel_code(sel_code), .safe_on(safe_on)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int    due;
        int    ch;
        int    sel;
        bit    safe;
        string tag;
    } exp_t;
    exp_t expq[$];

    task automatic chk_eq(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] ctrl_addr(int ch);
        return AW'(12'h300 + ch * 12'h40);
    endfunction

    function automatic logic [AW-1:0] stat_addr(int ch);
        return AW'(12'h304 + ch * 12'h40);
    endfunction

    function automatic logic [31:0] stat_word(int src, int cause, bit safe);
        return (32'(src) << 24) | (32'(cause) << 17) | (32'(safe) << 3);
    endfunction

    task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic wait_until(int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Driver: runs one switch, pushes the expected output state to the scoreboard
    task automatic do_switch(int ch, int sel, bit sw, bit sf, int exp_src, int exp_cause,
                             bit exp_safe, bit inject, string tag);
        int k;
        logic [31:0] d;
        logic [31:0] cw;
        k = cyc;
        cw = (32'(sel) << 24) | (32'(sf) << 3) | (32'(sw) << 2);
        bus_write(ctrl_addr(ch), cw);
        bus_read(ctrl_addr(ch), d);
        chk_eq({"R2 control latched: ", tag}, d, cw);
        @(negedge clk);
        bus_read(ctrl_addr(ch), d);
        chk_eq({"R3 request bits self-cleared: ", tag}, d, 32'(sel) << 24);
        bus_read(stat_addr(ch), d);
        chk_eq({"R5 busy set after accept: ", tag}, 32'(d[16]), 32'd1);
        expq.push_back('{k + 2 + CYC, ch, exp_src, exp_safe, tag});
        if (inject) begin
            bus_write(ctrl_addr(ch), (32'd6 << 24) | 32'h4);
            bus_read(ctrl_addr(ch), d);
            chk_eq({"R9 control write ignored while busy: ", tag}, d, 32'(sel) << 24);
        end
        wait_until(k + 1 + CYC);
        bus_read(stat_addr(ch), d);
        chk_eq({"R5 busy held on last cycle: ", tag}, 32'(d[16]), 32'd1);
        @(negedge clk);
        bus_read(stat_addr(ch), d);
        chk_eq({"R4 final status: ", tag}, d, stat_word(exp_src, exp_cause, exp_safe));
        @(negedge clk);
    endtask

    // Monitor: compares the select outputs when each switch is due to finish
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            while (expq.size() > 0 && expq[0].due <= cyc) begin
                e = expq.pop_front();
                if (e.due != cyc) begin
                    checks++;
                    errors++;
                    $display("FAIL %s: monitor missed due cycle, actual %0d expected %0d",
                             e.tag, cyc, e.due);
                end else begin
                    chk_eq({"R6 select code output: ", e.tag},
                           32'(sel_code[e.ch*6 +: 6]), 32'(e.sel));
                    chk_eq({"R7 safe output: ", e.tag},
                           32'(safe_on[e.ch]), 32'(e.safe));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        @(negedge clk);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        bus_read(ctrl_addr(0), d);  chk_eq("R10 ctrl0 after reset", d, 32'h0);
        bus_read(stat_addr(0), d);  chk_eq("R10 stat0 after reset", d, 32'h0);
        bus_read(stat_addr(1), d);  chk_eq("R10 stat1 after reset", d, 32'h0);
        chk_eq("R10 sel_code after reset", 32'(sel_code), 32'h0);
        chk_eq("R10 safe_on after reset", 32'(safe_on), 32'h0);

        src_good = 8'b1101_1111;

        do_switch(0, 3, 1'b1, 1'b0, 3, 1, 1'b0, 1'b0, "R6 ch0 to good source 3");
        do_switch(1, 7, 1'b1, 1'b0, 7, 1, 1'b0, 1'b0, "R11 ch1 to good source 7");
        bus_read(stat_addr(0), d);
        chk_eq("R11 ch0 untouched by ch1 switch", d, stat_word(3, 1, 1'b0));
        chk_eq("R11 ch0 select output untouched", 32'(sel_code[5:0]), 32'd3);

        do_switch(0, 5, 1'b1, 1'b0, 0, 4, 1'b1, 1'b0, "R8 dead source 5 falls back");
        do_switch(0, 1, 1'b0, 1'b1, 0, 5, 1'b1, 1'b0, "R7 safe request while safe");
        do_switch(0, 2, 1'b1, 1'b0, 2, 1, 1'b0, 1'b1, "R9 switch with late write");
        do_switch(0, 4, 1'b1, 1'b1, 0, 4, 1'b1, 1'b0, "R7 safe wins over switch");
        do_switch(1, 9, 1'b1, 1'b0, 0, 4, 1'b1, 1'b0, "R8 out-of-range source 9");

        src_good = 8'b1101_0111;
        do_switch(1, 3, 1'b1, 1'b0, 0, 5, 1'b1, 1'b0, "R8 dead source 3 while safe");
        src_good = 8'b1101_1111;

        // R2 write with no request bit
        bus_write(ctrl_addr(0), 32'd6 << 24);
        repeat (CYC + 2) @(negedge clk);
        bus_read(ctrl_addr(0), d);  chk_eq("R2 source stored without request", d, 32'd6 << 24);
        bus_read(stat_addr(0), d);  chk_eq("R2 no switch without request", d, stat_word(0, 4, 1'b1));
        chk_eq("R2 select output unchanged", 32'(sel_code[5:0]), 32'd0);

        // R1 address map
        bus_read(12'h308, d);  chk_eq("R1 unmapped 0x308 reads 0", d, 32'h0);
        bus_read(12'h380, d);  chk_eq("R1 missing channel 2 reads 0", d, 32'h0);
        bus_read(12'h2FC, d);  chk_eq("R1 below window reads 0", d, 32'h0);
        bus_read(12'h340, d);  chk_eq("R1 ch1 control at 0x340", d, 32'd3 << 24);
        bus_write(12'h304, 32'hFFFF_FFFF);
        bus_write(12'h380, 32'h0800_0004);
        repeat (CYC + 2) @(negedge clk);
        bus_read(stat_addr(0), d);  chk_eq("R1 status write ignored", d, stat_word(0, 4, 1'b1));
        bus_read(ctrl_addr(0), d);  chk_eq("R1 ctrl0 untouched by stray writes", d, 32'd6 << 24);
        bus_read(stat_addr(1), d);  chk_eq("R1 stat1 untouched by stray writes", d, stat_word(0, 5, 1'b1));

        repeat (3) @(negedge clk);
        chk_eq("R5 all scoreboard items retired", 32'(expq.size()), 32'd0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule